// File: doc/BRIEF.md
# Masked Clock-Phase Control Register Pair

This block keeps two 16-bit phase settings, one for the clock that drives data to a card and one for the clock that samples data from it. Each setting goes to an external adjustable delay line as a coarse quarter-period select, a fine-delay enable and an 8-bit fine tap count. The decode of those three fields is registered.

Software reaches both settings through a simple word-addressed bus port. Every 32-bit write carries its own bit mask in the upper half: data bit n of the lower half lands in the register only when bit n+16 of the same word is set. Software can therefore change one field without a read-modify-write. A bus read returns the stored 16 bits, zero-extended to 32 bits.

The control fields start one bit above the register's least significant bit. The fine tap count reaches the delay line only while the enable bit is set.

Top module: `phase_ctl_regs`

## Requirements
- R1: While reset is high and after it, both registers, all decoded outputs and the read data are zero until a write occurs.
- R2: On a write, register bit n (0..15) takes write-data bit n when write-data bit n+16 is 1, and keeps its previous value otherwise.
- R3: A read request returns the addressed register's 16 stored bits in read-data bits [15:0] on the clock edge that accepts it, with bits [31:16] zero. An unmapped address reads as zero.
- R4: The coarse select output equals register bits [2:1], in units of 90 degrees (0, 90, 180 or 270).
- R5: The fine enable output equals register bit 11. The tap output equals register bits [10:3] while bit 11 is 1, and is zero while bit 11 is 0, whatever count is stored.
- R6: The drive setting sits at byte address 0x130 and the sample setting at 0x134. A write to one leaves the other unchanged, and a write to any other address changes neither.
- R7: Decoded outputs follow a register change one clock edge after the edge that wrote the register.
- R8: Register bits 0 and [15:12] are stored and read back but have no effect on any decoded output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| bus_rdata | output | 32 | Registered read data |
| drv_quad | output | 2 | Drive clock coarse select |
| drv_fine_en | output | 1 | Drive clock fine delay enable |
| drv_taps | output | 8 | Drive clock fine tap count |
| smp_quad | output | 2 | Sample clock coarse select |
| smp_fine_en | output | 1 | Sample clock fine delay enable |
| smp_taps | output | 8 | Sample clock fine tap count |

## Verification
The decode is swept for both channels with a full-mask write of every coarse select, sixteen spread tap counts and both enable states. This separates a field taken from the wrong bit position from a tap gate that does not work. Pseudo-random words, each with its own random enable mask, then go to both mapped addresses and to an unmapped one. This shows whether a write preserves the unmasked bits, routes to the right register, and leaves the spare bits without effect. After every write both registers are read back and all outputs are compared against a bench model.

// File: rtl/phase_ctl_pkg.sv
package phase_ctl_pkg;
  localparam int HALF_W  = 16;
  localparam int QUAD_W  = 2;
  localparam int TAP_W   = 8;
  localparam int FLD_LSB = 1;
  localparam int FLD_W   = QUAD_W + TAP_W + 1;
  localparam int FLD_MSB = FLD_LSB + FLD_W - 1;

  typedef struct packed {
    logic              fine_en;
    logic [TAP_W-1:0]  taps;
    logic [QUAD_W-1:0] quad;
  } phase_cfg_t;
endpackage

// File: rtl/phase_mask_reg.sv
module phase_mask_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (wr_en) q <= (q & ~wmask) | (wdata & wmask);
  end

  p_keep_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask))));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import phase_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [FLD_W-1:0]   fld_i,
  output phase_cfg_t         cfg_o
);
  logic              en_bit;
  logic [TAP_W-1:0]  tap_bits;
  logic [QUAD_W-1:0] quad_bits;

  assign quad_bits = fld_i[QUAD_W-1:0];
  assign tap_bits  = fld_i[QUAD_W +: TAP_W];
  assign en_bit    = fld_i[FLD_W-1];

  always_ff @(posedge clk) begin
    if (rst) cfg_o <= '0;
    else begin
      cfg_o.quad    <= quad_bits;
      cfg_o.fine_en <= en_bit;
      cfg_o.taps    <= en_bit ? tap_bits : '0;
    end
  end

  p_quad_lag_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cfg_o.quad == $past(fld_i[QUAD_W-1:0]));
  p_taps_gated_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_o.fine_en |-> cfg_o.taps == '0);
endmodule

// File: rtl/phase_ctl_regs.sv
module phase_ctl_regs
  import phase_ctl_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] DRV_ADDR = 12'h130,
  parameter logic [11:0] SMP_ADDR = 12'h134
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        drv_quad,
  output logic              drv_fine_en,
  output logic [7:0]        drv_taps,
  output logic [1:0]        smp_quad,
  output logic              smp_fine_en,
  output logic [7:0]        smp_taps
);
  localparam int NCH = 2;

  logic [NCH-1:0]    hit;
  logic [HALF_W-1:0] regs [NCH];
  phase_cfg_t        cfg  [NCH];

  assign hit[0] = (bus_addr == ADDR_W'(DRV_ADDR));
  assign hit[1] = (bus_addr == ADDR_W'(SMP_ADDR));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    phase_mask_reg #(.W(HALF_W)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .wr_en (bus_sel && bus_we && hit[c]),
      .wdata (bus_wdata[HALF_W-1:0]),
      .wmask (bus_wdata[2*HALF_W-1:HALF_W]),
      .q     (regs[c])
    );
    phase_decode u_dec (
      .clk   (clk),
      .rst   (rst),
      .fld_i (regs[c][FLD_MSB:FLD_LSB]),
      .cfg_o (cfg[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_we) begin
      if (hit[0])      bus_rdata <= {{HALF_W{1'b0}}, regs[0]};
      else if (hit[1]) bus_rdata <= {{HALF_W{1'b0}}, regs[1]};
      else             bus_rdata <= '0;
    end
  end

  assign drv_quad    = cfg[0].quad;
  assign drv_fine_en = cfg[0].fine_en;
  assign drv_taps    = cfg[0].taps;
  assign smp_quad    = cfg[1].quad;
  assign smp_fine_en = cfg[1].fine_en;
  assign smp_taps    = cfg[1].taps;

  p_rdata_upper_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:16] == '0);
  p_unmapped_write_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && hit == '0) |=> ($stable(regs[0]) && $stable(regs[1])));
  p_drv_only_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && hit[0]) |=> $stable(regs[1]));
endmodule

// File: tb/phase_ctl_regs_tb.sv
module phase_ctl_regs_tb;
  logic        clk = 0, rst = 1;
  logic        bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  drv_quad, smp_quad;
  logic        drv_fine_en, smp_fine_en;
  logic [7:0]  drv_taps, smp_taps;

  int n_tests = 0, n_fail = 0;
  logic [15:0] m_drv = '0, m_smp = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  logic        done = 0;

  always #10 clk = ~clk;

  phase_ctl_regs u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    if (a == 12'h130) m_drv = (m_drv & ~d[31:16]) | (d[15:0] & d[31:16]);
    if (a == 12'h134) m_smp = (m_smp & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(req, bus_rdata, exp);
  endtask

  // one negedge after wr returns: one more edge has passed (R7 lag)
  task automatic chk_outs(input string req);
    @(negedge clk);
    chk({req, " drv quad R4"}, {30'b0, drv_quad}, {30'b0, m_drv[2:1]});
    chk({req, " drv en R5"},   {31'b0, drv_fine_en}, {31'b0, m_drv[11]});
    chk({req, " drv taps R5"}, {24'b0, drv_taps}, m_drv[11] ? {24'b0, m_drv[10:3]} : 32'b0);
    chk({req, " smp quad R4"}, {30'b0, smp_quad}, {30'b0, m_smp[2:1]});
    chk({req, " smp en R5"},   {31'b0, smp_fine_en}, {31'b0, m_smp[11]});
    chk({req, " smp taps R5"}, {24'b0, smp_taps}, m_smp[11] ? {24'b0, m_smp[10:3]} : 32'b0);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset drv_taps", {24'b0, drv_taps}, 32'b0);
    chk("R1 reset rdata", bus_rdata, 32'b0);
    rst = 0;
    rd(12'h130, 32'b0, "R1 drv after reset");
    rd(12'h134, 32'b0, "R1 smp after reset");
    chk_outs("R1");

    // R4/R5 sweep with full mask on both channels
    for (int ch = 0; ch < 2; ch++)
      for (int q = 0; q < 4; q++)
        for (int t = 0; t < 256; t += 17)
          for (int e = 0; e < 2; e++) begin
            logic [15:0] v = {4'b0, e[0], t[7:0], q[1:0], 1'b0};
            wr(ch ? 12'h134 : 12'h130, {16'hFFFF, v});
            chk_outs("R4 R5 R7 sweep");
          end

    // R8: spare bits written alone, outputs unchanged, readback holds them
    wr(12'h130, 32'hF001_F001);
    chk_outs("R8 spare");
    rd(12'h130, {16'b0, m_drv}, "R8 spare readback");

    // R2/R6: masked random writes incl. unmapped address
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      lfsr = nxt(lfsr);
      a = (lfsr[1:0] == 2'd0) ? 12'h130 : (lfsr[1:0] == 2'd1) ? 12'h134 :
          (lfsr[1:0] == 2'd2) ? 12'h138 : 12'h12C;
      lfsr = nxt(lfsr);
      wr(a, lfsr);
      chk_outs("R2 R6 masked");
      rd(12'h130, {16'b0, m_drv}, "R2 R6 drv readback");
      rd(12'h134, {16'b0, m_smp}, "R2 R6 smp readback");
    end
    rd(12'h200, 32'b0, "R3 unmapped read");

    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_drv = '0; m_smp = '0;
    chk_outs("R1 re-reset");
    rd(12'h134, 32'b0, "R1 smp re-reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule